// File: doc/BRIEF.md
# Shared-Memory Mailbox Aperture

This block is a small register window that two agents use to pass messages. One is a requester, the virtual-function side. The other is a responder, the physical-function side. The window holds eight 32-bit dwords, and each side reaches it through its own simple register port. Writes on either port take effect at the clock edge. Reads return data one cycle after the read strobe.

The top dword is the protocol header. Its most significant bit is the owner flag: 0 means the requester owns the window and 1 means the responder owns it. Ownership moves without any explicit command:

- When the requester writes the header, the window stores the value with the owner flag forced to 1. It also sends a one-cycle notify pulse to the responder.
- When the responder writes its answer into the header, the flag is cleared and ownership returns to the requester.

While the function is held in reset, the requester sees all ones on every read, and its writes are dropped. The payload layout and the header fields below the owner flag are carried as plain data.

Top module: `mbox_aperture`

## Requirements
- R1: After the synchronous reset, every dword reads as zero. The owner flag (bit 31 of dword 7) is 0, and both read data outputs, the error flag and the notify pulse are 0.
- R2: While the requester owns the window and the function is not in reset, a requester write to dwords 0 to 6 is stored. A read strobe returns the stored dword on the read data output one cycle later.
- R3: A requester write to dword 7 that the window accepts stores the written bits 30:0 and sets bit 31 to 1, handing ownership to the responder.
- R4: `rsp_notify` is high for exactly the one cycle after each accepted requester write to dword 7, and at no other time.
- R5: While bit 31 of dword 7 is 1, every requester write to any dword is ignored and sets `req_err`. `req_err` stays set until reset.
- R6: A request made of a single write to dword 7 leaves dwords 0 to 6 with their previous contents.
- R7: A responder write to dword 7 stores bits 30:0 and clears bit 31, returning ownership. Responder writes to dwords 0 to 6 are stored as written.
- R8: While `fn_in_reset` is high, a requester read returns 0xFFFFFFFF and requester writes are ignored without setting `req_err`. Responder reads still return the stored data.
- R9: When both sides write the same dword in the same cycle, the responder value is stored. If that dword is 7, no notify pulse follows.
- R10: The responder port reads back any payload the requester wrote, with the same one-cycle read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_in_reset | input | 1 | Function held in reset; requester reads all ones |
| req_wr | input | 1 | Requester write strobe |
| req_rd | input | 1 | Requester read strobe |
| req_addr | input | 3 | Requester dword index |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data, one cycle after strobe |
| req_err | output | 1 | Sticky flag: requester wrote while not owner |
| rsp_wr | input | 1 | Responder write strobe |
| rsp_rd | input | 1 | Responder read strobe |
| rsp_addr | input | 3 | Responder dword index |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data, one cycle after strobe |
| rsp_notify | output | 1 | One-cycle pulse when ownership passes to responder |

## Verification
The bench builds the block with its default parameters: eight dwords of 32 bits. With those values the owner flag sits at bit 31 of index 7, exactly where the header layout puts it. This makes reachable the full exchange:

- a payload write followed by the header hand-off;
- blocked writes while the responder owns the window;
- the response that returns ownership;
- a header-only request;
- the all-ones reads while the function is in reset;
- the same-cycle collision on the header dword.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {
    OWNER_REQ = 1'b0,
    OWNER_RSP = 1'b1
  } owner_e;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic          a_mask,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  output logic [DW-1:0] b_rdata,
  output logic          owner_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_we) mem[a_addr] <= a_data;
      if (b_we) mem[b_addr] <= b_data;
      if (a_re) a_rdata <= a_mask ? '1 : mem[a_addr];
      if (b_re) b_rdata <= mem[b_addr];
    end
  end

  assign owner_o = mem[WORDS-1][DW-1];

  // R8: a read taken while the function is in reset returns all ones
  a_r8_masked_read: assert property (@(posedge clk) disable iff (rst)
    (a_re && a_mask) |=> (a_rdata == '1));
endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
  import mbox_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fn_in_reset,
  input  owner_e        owner,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rsp_wr,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_wdata,
  output logic          a_we,
  output logic [DW-1:0] a_data,
  output logic          b_we,
  output logic [DW-1:0] b_data,
  output logic          err_o,
  output logic          notify_o
);
  localparam logic [AW-1:0] HDR_IDX = AW'(WORDS - 1);
  localparam logic [DW-1:0] OWN_MSK = DW'(1) << (DW - 1);

  logic req_live, req_hdr, rsp_hdr, handoff;

  always_comb begin
    req_live = req_wr && !fn_in_reset;
    req_hdr  = (req_addr == HDR_IDX);
    rsp_hdr  = (rsp_addr == HDR_IDX);
    a_we     = req_live && (owner == OWNER_REQ);
    a_data   = req_hdr ? (req_wdata | OWN_MSK) : req_wdata;
    b_we     = rsp_wr;
    b_data   = rsp_hdr ? (rsp_wdata & ~OWN_MSK) : rsp_wdata;
    handoff  = a_we && req_hdr && !(rsp_wr && rsp_hdr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o    <= 1'b0;
      notify_o <= 1'b0;
    end else begin
      notify_o <= handoff;
      if (req_live && owner == OWNER_RSP) err_o <= 1'b1;
    end
  end

  // R4: the pulse only appears once the responder holds the window
  a_r4_notify_owner: assert property (@(posedge clk) disable iff (rst)
    notify_o |-> (owner == OWNER_RSP));
  // R4: the pulse lasts one cycle
  a_r4_notify_single: assert property (@(posedge clk) disable iff (rst)
    notify_o |=> !notify_o);
  // R5: the error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  // R5: a blocked write alters no dword through the requester side
  a_r5_blocked: assert property (@(posedge clk) disable iff (rst)
    (owner == OWNER_RSP) |-> !a_we);
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
  import mbox_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fn_in_reset,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  output logic          req_err,
  input  logic          rsp_wr,
  input  logic          rsp_rd,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_notify
);
  localparam logic [AW-1:0] HDR_IDX = AW'(WORDS - 1);

  logic          a_we, b_we, owner_bit;
  logic [DW-1:0] a_data, b_data;
  owner_e        owner;

  assign owner = owner_e'(owner_bit);

  mbox_ctl #(.WORDS(WORDS), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .fn_in_reset(fn_in_reset), .owner(owner),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_wr(rsp_wr), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata),
    .a_we(a_we), .a_data(a_data), .b_we(b_we), .b_data(b_data),
    .err_o(req_err), .notify_o(rsp_notify)
  );

  mbox_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_re(req_rd), .a_mask(fn_in_reset), .a_addr(req_addr),
    .a_data(a_data), .a_rdata(req_rdata),
    .b_we(b_we), .b_re(rsp_rd), .b_addr(rsp_addr),
    .b_data(b_data), .b_rdata(rsp_rdata),
    .owner_o(owner_bit)
  );

  // R3: an accepted header write from the requester hands over the window
  a_r3_handoff: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !fn_in_reset && owner == OWNER_REQ && req_addr == HDR_IDX
     && !(rsp_wr && rsp_addr == HDR_IDX)) |=> (owner == OWNER_RSP));
  // R7: a responder header write returns the window
  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (rsp_wr && rsp_addr == HDR_IDX) |=> (owner == OWNER_REQ));
  // R8: function reset suppresses the error flag for requester writes
  a_r8_no_err: assert property (@(posedge clk) disable iff (rst)
    (!req_err && fn_in_reset) |=> !req_err);
endmodule

// File: tb/mbox_aperture_bench.sv
module mbox_aperture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fn_in_reset = 1'b0;
  logic        req_wr = 1'b0, req_rd = 1'b0, rsp_wr = 1'b0, rsp_rd = 1'b0;
  logic [2:0]  req_addr = '0, rsp_addr = '0;
  logic [31:0] req_wdata = '0, rsp_wdata = '0;
  logic [31:0] req_rdata, rsp_rdata;
  logic        req_err, rsp_notify;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mbox_aperture u_mbox_aperture (
    .clk(clk), .rst(rst), .fn_in_reset(fn_in_reset),
    .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_err(req_err),
    .rsp_wr(rsp_wr), .rsp_rd(rsp_rd), .rsp_addr(rsp_addr),
    .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata), .rsp_notify(rsp_notify)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rq_write(input logic [2:0] a, input logic [31:0] d);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rp_write(input logic [2:0] a, input logic [31:0] d);
    rsp_wr = 1'b1; rsp_addr = a; rsp_wdata = d;
    @(negedge clk);
    rsp_wr = 1'b0;
  endtask

  task automatic rq_read(input logic [2:0] a, output logic [31:0] d);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    d = req_rdata; req_rd = 1'b0;
  endtask

  task automatic rp_read(input logic [2:0] a, output logic [31:0] d);
    rsp_rd = 1'b1; rsp_addr = a;
    @(negedge clk);
    d = rsp_rdata; rsp_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 req_rdata", req_rdata, 32'h0);
    chk("R1 rsp_rdata", rsp_rdata, 32'h0);
    chk("R1 err", {31'b0, req_err}, 32'h0);
    chk("R1 notify", {31'b0, rsp_notify}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rq_read(3'(i), d);
      chk("R1 dword", d, 32'h0);
    end
  endtask

  task automatic t_payload;
    logic [31:0] d;
    for (int i = 0; i < 7; i++) rq_write(3'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 7; i++) begin
      rq_read(3'(i), d);
      chk("R2 req readback", d, 32'h1000_0000 + i);
      rp_read(3'(i), d);
      chk("R10 rsp readback", d, 32'h1000_0000 + i);
    end
    chk("R4 no notify on payload", {31'b0, rsp_notify}, 32'h0);
  endtask

  task automatic t_handoff;
    logic [31:0] d;
    rq_write(3'd7, 32'h0000_0001);
    chk("R4 notify high", {31'b0, rsp_notify}, 32'h1);
    @(negedge clk);
    chk("R4 notify low", {31'b0, rsp_notify}, 32'h0);
    rq_read(3'd7, d);
    chk("R3 header owner set", d, 32'h8000_0001);
  endtask

  task automatic t_blocked;
    logic [31:0] d;
    rq_write(3'd2, 32'hDEAD_BEEF);
    chk("R5 err set", {31'b0, req_err}, 32'h1);
    rq_write(3'd7, 32'h0000_0003);
    chk("R5 no notify on blocked header", {31'b0, rsp_notify}, 32'h0);
    rp_read(3'd2, d);
    chk("R5 dword2 kept", d, 32'h1000_0002);
    rp_read(3'd7, d);
    chk("R5 header kept", d, 32'h8000_0001);
  endtask

  task automatic t_response;
    logic [31:0] d;
    rp_write(3'd7, 32'h8000_0081);
    rq_read(3'd7, d);
    chk("R7 owner cleared", d, 32'h0000_0081);
    chk("R5 err still set", {31'b0, req_err}, 32'h1);
    rp_write(3'd5, 32'hA5A5_0005);
    rq_read(3'd5, d);
    chk("R7 rsp payload write", d, 32'hA5A5_0005);
    rq_write(3'd5, 32'h1000_0005);
    rq_read(3'd5, d);
    chk("R7 requester accepted again", d, 32'h1000_0005);
  endtask

  task automatic t_header_only;
    logic [31:0] d;
    rq_write(3'd7, 32'h0100_0002);
    chk("R4 notify header-only", {31'b0, rsp_notify}, 32'h1);
    for (int i = 0; i < 7; i++) begin
      rp_read(3'(i), d);
      chk("R6 payload retained", d, 32'h1000_0000 + i);
    end
    rp_read(3'd7, d);
    chk("R3 header-only value", d, 32'h8100_0002);
    rp_write(3'd7, 32'h0000_0082);
  endtask

  task automatic t_fnreset;
    logic [31:0] d;
    fn_in_reset = 1'b1;
    rq_read(3'd3, d);
    chk("R8 all ones dword3", d, 32'hFFFF_FFFF);
    rq_read(3'd7, d);
    chk("R8 all ones header", d, 32'hFFFF_FFFF);
    rp_read(3'd3, d);
    chk("R8 rsp unaffected", d, 32'h1000_0003);
    rq_write(3'd3, 32'h0BAD_0BAD);
    rq_write(3'd7, 32'h0000_0001);
    chk("R8 no notify", {31'b0, rsp_notify}, 32'h0);
    fn_in_reset = 1'b0;
    rq_read(3'd3, d);
    chk("R8 write ignored", d, 32'h1000_0003);
    rq_read(3'd7, d);
    chk("R8 header kept", d, 32'h0000_0082);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    req_wr = 1'b1; req_addr = 3'd7; req_wdata = 32'h0000_0005;
    rsp_wr = 1'b1; rsp_addr = 3'd7; rsp_wdata = 32'h0000_0006;
    @(negedge clk);
    req_wr = 1'b0; rsp_wr = 1'b0;
    chk("R9 no notify", {31'b0, rsp_notify}, 32'h0);
    rq_read(3'd7, d);
    chk("R9 responder wins", d, 32'h0000_0006);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_payload();
    t_handoff();
    t_blocked();
    t_response();
    t_header_only();
    t_fnreset();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule